// File: doc/BRIEF.md
# Parameterized Floating-Point Adder

This block adds two binary floating-point operands and returns their rounded sum with a status byte. It is purely combinational. Exponent and fraction widths are parameters. The default is the 32-bit single format, and the 16-bit half format is a supported setting. The datapath has five stages:

- unpack both words;
- order the operands by magnitude;
- align the smaller operand, keeping guard, round and sticky information;
- add or subtract the aligned significands;
- normalize, round in the selected mode and repack.

Zeros, infinities, subnormals and not-a-number inputs are all recognised.

A compliance parameter picks between two behaviours. At 1 the block gives full gradual-underflow and not-a-number handling. At 0 it is a simpler variant: subnormal operands and subnormal results become zero, and not-a-number inputs count as infinity. The block is meant to sit inside a larger datapath, for example the accumulate half of a multiply-accumulate loop. The enclosing logic supplies any registers around it.

Top module: `fpadd_core`

## Requirements
- R1: Operand and result words are sign in the MSB, then an EXP_W-bit biased exponent, then an FRAC_W-bit fraction with a hidden leading 1 for nonzero exponents. For finite inputs, z equals the exact sum rounded to that format.
- R2: The `rnd` input selects the rounding mode: 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity, 4 nearest with ties away from zero, 5 away from zero. Codes 6 and 7 act as code 0.
- R3: With IEEE_MODE=1, sums below the smallest normal magnitude are returned as subnormals with exponent field 0, and status bit 3 (tiny) is set.
- R4: Any operand with an all-ones exponent and a nonzero fraction is a NaN. The result is then sign 0, exponent all ones and fraction 1, with status bit 2 (invalid) set.
- R5: Infinity plus the infinity of opposite sign sets status bit 2. The result is the NaN pattern of R4 when IEEE_MODE=1, and +infinity with status bit 1 also set when IEEE_MODE=0.
- R6: Otherwise, an infinite operand gives an infinity of that operand's sign, and status bit 1 (infinity) is set.
- R7: A finite sum whose rounded exponent reaches all ones sets status bits 4 (huge) and 5 (inexact). The result is infinity for modes 0, 4, 5, for mode 2 with a positive sign and for mode 3 with a negative sign; otherwise it is the largest finite value of that sign.
- R8: An exact zero sum of operands with opposite signs is +0, except -0 in mode 3. The sum of two zeros of the same sign keeps that sign. Status bit 0 (zero) is set exactly when z is a zero.
- R9: Status bit 5 (inexact) is set whenever z differs from the exact sum.
- R10: With IEEE_MODE=0, subnormal operands act as zeros and NaN operands act as infinities. A result that would be subnormal becomes a zero of the same sign, with status bits 0, 3 and 5 set.
- R11: Status bits 6 (huge-integer) and 7 (divide-by-zero) are always 0.
- R12: With EXP_W=5 and FRAC_W=10, the block meets R1 to R9 on 16-bit words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 1+EXP_W+FRAC_W | First addend |
| b | input | 1+EXP_W+FRAC_W | Second addend |
| rnd | input | 3 | Rounding-mode select |
| z | output | 1+EXP_W+FRAC_W | Rounded sum |
| status | output | 8 | Exception and result flags |

## Verification
The block holds no state, so any wrong internal value shows at `z` or `status` in the same evaluation as the inputs that exercise it.

The failure modes are distinct at the ports:
- A lost sticky bit or a wrong alignment shift shows only in the last fraction bit. It appears only under a rounding mode that is sensitive to that bit.
- A normalization fault after heavy cancellation shows as a shifted fraction or a wrong exponent.
- A swap or sign fault shows as a wrong result sign, mostly on near-equal operands of opposite sign.

The stimulus therefore mixes cancellation pairs, near-overflow and near-underflow exponents, and every rounding code.

// File: rtl/fpadd_pkg.sv
// Shared definitions for the floating-point adder: rounding-mode codes,
// status bit positions and the per-mode round-increment decision.
// Assumes the mode code is 3 bits wide; unlisted codes fall back to
// nearest-even.
package fpadd_pkg;

    typedef enum logic [2:0] {
        RM_NEAR_EVEN = 3'd0,
        RM_ZERO      = 3'd1,
        RM_POS       = 3'd2,
        RM_NEG       = 3'd3,
        RM_NEAR_UP   = 3'd4,
        RM_AWAY      = 3'd5
    } rmode_e;

    localparam int STAT_W     = 8;
    localparam int ST_ZERO    = 0;
    localparam int ST_INF     = 1;
    localparam int ST_INVALID = 2;
    localparam int ST_TINY    = 3;
    localparam int ST_HUGE    = 4;
    localparam int ST_INEXACT = 5;
    localparam int ST_HUGEINT = 6;
    localparam int ST_DIVZ    = 7;

    // Decide whether the kept magnitude is incremented by one unit.
    function automatic logic round_incr(input logic [2:0] mode, input logic sign,
                                        input logic lsb, input logic guard,
                                        input logic sticky);
        logic inexact;
        inexact = guard | sticky;
        case (mode)
            RM_ZERO:    round_incr = 1'b0;
            RM_POS:     round_incr = inexact & ~sign;
            RM_NEG:     round_incr = inexact & sign;
            RM_NEAR_UP: round_incr = guard;
            RM_AWAY:    round_incr = inexact;
            default:    round_incr = guard & (sticky | lsb);
        endcase
    endfunction

    // Decide whether an overflowing result saturates to infinity.
    function automatic logic ovf_is_inf(input logic [2:0] mode, input logic sign);
        case (mode)
            RM_ZERO: ovf_is_inf = 1'b0;
            RM_POS:  ovf_is_inf = ~sign;
            RM_NEG:  ovf_is_inf = sign;
            default: ovf_is_inf = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/fpadd_unpack.sv
// Operand unpacker: splits one word into sign, effective biased exponent
// and significand with the hidden bit made explicit, and classifies it.
// Subnormals get effective exponent 1 and a hidden bit of 0. With
// IEEE_MODE=0 a subnormal becomes zero and a NaN is reported as infinity.
module fpadd_unpack #(
    parameter int EXP_W     = 8,
    parameter int FRAC_W    = 23,
    parameter int IEEE_MODE = 1,
    localparam int WORD_W   = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] op,
    output logic              sign,
    output logic [EXP_W-1:0]  exp_eff,
    output logic [FRAC_W:0]   sig,
    output logic              is_nan,
    output logic              is_inf,
    output logic              is_zero
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_all1;
    logic              exp_all0;

    assign exp_f    = op[WORD_W-2:FRAC_W];
    assign frac_f   = op[FRAC_W-1:0];
    assign exp_all1 = &exp_f;
    assign exp_all0 = (exp_f == '0);

    // Classify the operand and rebuild its significand.
    always_comb begin
        sign   = op[WORD_W-1];
        is_nan = 1'b0;
        is_inf = 1'b0;
        if (exp_all1) begin
            if ((frac_f != '0) && (IEEE_MODE != 0)) is_nan = 1'b1;
            else                                    is_inf = 1'b1;
        end
        if (exp_all0) begin
            exp_eff = {{(EXP_W-1){1'b0}}, 1'b1};
            sig     = (IEEE_MODE != 0) ? {1'b0, frac_f} : '0;
        end else begin
            exp_eff = exp_f;
            sig     = {1'b1, frac_f};
        end
        is_zero = exp_all0 && (sig == '0);
    end

endmodule

// File: rtl/fpadd_align.sv
// Swap and align stage: orders the operands by magnitude, shifts the
// smaller one right by the exponent difference, and folds every bit
// shifted past the last three positions into a sticky bit. It then adds
// or subtracts. The larger operand comes first, so the sum is never
// negative.
module fpadd_align #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int SIG_W = FRAC_W + 1,
    localparam int EXT_W = FRAC_W + 4,
    localparam int SH_W  = $clog2(EXT_W + 1)
) (
    input  logic              sign_a,
    input  logic [EXP_W-1:0]  exp_a,
    input  logic [SIG_W-1:0]  sig_a,
    input  logic              sign_b,
    input  logic [EXP_W-1:0]  exp_b,
    input  logic [SIG_W-1:0]  sig_b,
    output logic              res_sign,
    output logic              eff_sub,
    output logic [EXP_W-1:0]  exp_big,
    output logic [EXT_W:0]    sum
);

    logic              a_first;
    logic [EXP_W-1:0]  exp_sml;
    logic [SIG_W-1:0]  sig_big;
    logic [SIG_W-1:0]  sig_sml;
    logic [EXP_W-1:0]  diff;
    logic [SH_W-1:0]   sh;
    logic [EXT_W-1:0]  sml_ext;
    logic [EXT_W-1:0]  shifted;
    logic [EXT_W-1:0]  lost_mask;
    logic              lost;
    logic [EXT_W-1:0]  sml_al;
    logic [EXT_W-1:0]  big_ext;

    assign a_first = ({exp_a, sig_a} >= {exp_b, sig_b});
    assign eff_sub = sign_a ^ sign_b;

    // Route the larger magnitude to the big path.
    always_comb begin
        if (a_first) begin
            res_sign = sign_a;
            exp_big  = exp_a;
            sig_big  = sig_a;
            exp_sml  = exp_b;
            sig_sml  = sig_b;
        end else begin
            res_sign = sign_b;
            exp_big  = exp_b;
            sig_big  = sig_b;
            exp_sml  = exp_a;
            sig_sml  = sig_a;
        end
    end

    // Right-shift the smaller significand and gather the sticky bit.
    always_comb begin
        diff      = exp_big - exp_sml;
        sh        = (int'(diff) >= EXT_W) ? SH_W'(EXT_W) : SH_W'(diff);
        sml_ext   = {sig_sml, 3'b000};
        shifted   = sml_ext >> sh;
        lost_mask = (int'(sh) >= EXT_W) ? '1 : ((EXT_W'(1) << sh) - EXT_W'(1));
        lost      = |(sml_ext & lost_mask);
        sml_al    = {shifted[EXT_W-1:1], shifted[0] | lost};
        big_ext   = {sig_big, 3'b000};
    end

    // Effective addition or subtraction of the aligned magnitudes.
    always_comb begin
        if (eff_sub) sum = {1'b0, big_ext} - {1'b0, sml_al};
        else         sum = {1'b0, big_ext} + {1'b0, sml_al};
    end

endmodule

// File: rtl/fpadd_norm.sv
// Normalizer: brings the raw sum back to a leading 1 in the hidden-bit
// position. A carry-out gives a one-bit right shift that keeps the sticky
// bit. Cancellation gives a left shift by the leading-zero count, limited
// so the exponent stops at 1; a result still lacking its hidden bit is a
// subnormal. Outputs the kept significand plus guard and sticky.
module fpadd_norm #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int EXT_W = FRAC_W + 4,
    localparam int LZ_W  = $clog2(EXT_W + 1)
) (
    input  logic [EXP_W-1:0] exp_big,
    input  logic [EXT_W:0]   sum,
    output logic [EXP_W:0]   e_n,
    output logic [FRAC_W:0]  mant,
    output logic             guard,
    output logic             sticky,
    output logic             zero_sum
);

    logic [LZ_W-1:0]  lz;
    logic [LZ_W-1:0]  shl;
    logic [EXP_W-1:0] headroom;
    logic [EXT_W-1:0] norm;

    // Leading-zero count below the carry position.
    always_comb begin
        lz = LZ_W'(EXT_W);
        for (int i = 0; i < EXT_W; i++) begin
            if (sum[i]) lz = LZ_W'(EXT_W - 1 - i);
        end
    end

    // Left shift limited by how far the exponent may still fall.
    always_comb begin
        headroom = exp_big - {{(EXP_W-1){1'b0}}, 1'b1};
        if (int'(lz) <= int'(headroom)) shl = lz;
        else                            shl = LZ_W'(headroom);
    end

    // Apply the normalizing shift and adjust the exponent.
    always_comb begin
        if (sum[EXT_W]) begin
            norm = {sum[EXT_W:2], sum[1] | sum[0]};
            e_n  = {1'b0, exp_big} + {{EXP_W{1'b0}}, 1'b1};
        end else begin
            norm = sum[EXT_W-1:0] << shl;
            e_n  = {1'b0, exp_big} - (EXP_W+1)'(shl);
        end
        mant     = norm[EXT_W-1:3];
        guard    = norm[2];
        sticky   = |norm[1:0];
        zero_sum = (sum == '0);
    end

endmodule

// File: rtl/fpadd_round.sv
// Rounder and packer for the finite path. Applies the mode-dependent
// increment and handles significand carry-out and overflow. Picks the
// sign of an exact zero and flushes subnormals when IEEE_MODE=0. Also
// drives the zero, infinity, tiny, huge and inexact flags.
// Assumes e_n >= 1 and that mant has no hidden bit only when e_n == 1.
module fpadd_round #(
    parameter int EXP_W     = 8,
    parameter int FRAC_W    = 23,
    parameter int IEEE_MODE = 1,
    localparam int WORD_W   = 1 + EXP_W + FRAC_W
) (
    input  logic              res_sign,
    input  logic              eff_sub,
    input  logic              sign_a,
    input  logic [2:0]        rnd,
    input  logic [EXP_W:0]    e_n,
    input  logic [FRAC_W:0]   mant,
    input  logic              guard,
    input  logic              sticky,
    input  logic              zero_sum,
    output logic [WORD_W-1:0] z_fin,
    output logic              f_zero,
    output logic              f_inf,
    output logic              f_tiny,
    output logic              f_huge,
    output logic              f_inexact
);
    import fpadd_pkg::*;

    localparam logic [EXP_W-1:0] EXP_ONES = '1;

    logic              up;
    logic [FRAC_W+1:0] mant_r;
    logic [EXP_W:0]    e_r;
    logic [FRAC_W-1:0] frac_r;
    logic              ovf;
    logic              to_inf;
    logic              zsign;

    // Round increment and carry handling.
    always_comb begin
        up     = round_incr(rnd, res_sign, mant[0], guard, sticky);
        mant_r = {1'b0, mant} + {{(FRAC_W+1){1'b0}}, up};
        if (mant_r[FRAC_W+1]) begin
            e_r    = e_n + {{EXP_W{1'b0}}, 1'b1};
            frac_r = mant_r[FRAC_W:1];
        end else begin
            e_r    = mant_r[FRAC_W] ? e_n : '0;
            frac_r = mant_r[FRAC_W-1:0];
        end
        ovf    = (e_r >= {1'b0, EXP_ONES});
        to_inf = ovf_is_inf(rnd, res_sign);
        zsign  = eff_sub ? (rnd == RM_NEG) : sign_a;
    end

    // Choose the packed word and flags for the finite path.
    always_comb begin
        f_zero    = 1'b0;
        f_inf     = 1'b0;
        f_tiny    = 1'b0;
        f_huge    = 1'b0;
        f_inexact = guard | sticky;
        z_fin     = {res_sign, e_r[EXP_W-1:0], frac_r};
        if (zero_sum) begin
            z_fin     = {zsign, {(WORD_W-1){1'b0}}};
            f_zero    = 1'b1;
            f_inexact = 1'b0;
        end else if (ovf) begin
            f_huge    = 1'b1;
            f_inexact = 1'b1;
            f_inf     = to_inf;
            if (to_inf) z_fin = {res_sign, EXP_ONES, {FRAC_W{1'b0}}};
            else        z_fin = {res_sign, EXP_ONES - 1'b1, {FRAC_W{1'b1}}};
        end else if (e_r == '0) begin
            f_tiny = 1'b1;
            if (IEEE_MODE == 0) begin
                z_fin     = {res_sign, {(WORD_W-1){1'b0}}};
                f_zero    = 1'b1;
                f_inexact = 1'b1;
            end
        end
    end

endmodule

// File: rtl/fpadd_core.sv
// Combinational floating-point adder, top level. Unpacks both operands,
// aligns and adds, normalizes, rounds and packs. Special operands
// (NaN, infinity, opposite infinities) override the finite path.
// Status layout is given by fpadd_pkg.
module fpadd_core #(
    parameter int EXP_W     = 8,
    parameter int FRAC_W    = 23,
    parameter int IEEE_MODE = 1,
    localparam int WORD_W   = 1 + EXP_W + FRAC_W,
    localparam int EXT_W    = FRAC_W + 4
) (
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic [2:0]        rnd,
    output logic [WORD_W-1:0] z,
    output logic [7:0]        status
);
    import fpadd_pkg::*;

    localparam logic [EXP_W-1:0] EXP_ONES = '1;

    logic [WORD_W-1:0] ops     [2];
    logic              op_sign [2];
    logic [EXP_W-1:0]  op_exp  [2];
    logic [FRAC_W:0]   op_sig  [2];
    logic              op_nan  [2];
    logic              op_inf  [2];
    logic              op_zero [2];

    assign ops[0] = a;
    assign ops[1] = b;

    for (genvar gi = 0; gi < 2; gi++) begin : g_unpack
        fpadd_unpack #(
            .EXP_W(EXP_W), .FRAC_W(FRAC_W), .IEEE_MODE(IEEE_MODE)
        ) u_unpack (
            .op(ops[gi]), .sign(op_sign[gi]), .exp_eff(op_exp[gi]),
            .sig(op_sig[gi]), .is_nan(op_nan[gi]), .is_inf(op_inf[gi]),
            .is_zero(op_zero[gi])
        );
    end

    logic              res_sign;
    logic              eff_sub;
    logic [EXP_W-1:0]  exp_big;
    logic [EXT_W:0]    sum;

    fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
        .sign_a(op_sign[0]), .exp_a(op_exp[0]), .sig_a(op_sig[0]),
        .sign_b(op_sign[1]), .exp_b(op_exp[1]), .sig_b(op_sig[1]),
        .res_sign(res_sign), .eff_sub(eff_sub), .exp_big(exp_big), .sum(sum)
    );

    logic [EXP_W:0]    e_n;
    logic [FRAC_W:0]   mant;
    logic              guard;
    logic              sticky;
    logic              zero_sum;

    fpadd_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
        .exp_big(exp_big), .sum(sum), .e_n(e_n), .mant(mant),
        .guard(guard), .sticky(sticky), .zero_sum(zero_sum)
    );

    logic [WORD_W-1:0] z_fin;
    logic              f_zero;
    logic              f_inf;
    logic              f_tiny;
    logic              f_huge;
    logic              f_inexact;

    fpadd_round #(
        .EXP_W(EXP_W), .FRAC_W(FRAC_W), .IEEE_MODE(IEEE_MODE)
    ) u_round (
        .res_sign(res_sign), .eff_sub(eff_sub), .sign_a(op_sign[0]),
        .rnd(rnd), .e_n(e_n), .mant(mant), .guard(guard), .sticky(sticky),
        .zero_sum(zero_sum), .z_fin(z_fin), .f_zero(f_zero), .f_inf(f_inf),
        .f_tiny(f_tiny), .f_huge(f_huge), .f_inexact(f_inexact)
    );

    logic any_nan;
    logic inf_clash;
    logic zero_pair;

    assign any_nan   = op_nan[0] | op_nan[1];
    assign inf_clash = op_inf[0] & op_inf[1] & (op_sign[0] ^ op_sign[1]);
    assign zero_pair = op_zero[0] & op_zero[1];

    // Select special-value results ahead of the finite datapath.
    always_comb begin
        status = '0;
        if (any_nan || (inf_clash && (IEEE_MODE != 0))) begin
            z                  = {1'b0, EXP_ONES, {(FRAC_W-1){1'b0}}, 1'b1};
            status[ST_INVALID] = 1'b1;
        end else if (inf_clash) begin
            z                  = {1'b0, EXP_ONES, {FRAC_W{1'b0}}};
            status[ST_INVALID] = 1'b1;
            status[ST_INF]     = 1'b1;
        end else if (op_inf[0] || op_inf[1]) begin
            z              = {op_inf[0] ? op_sign[0] : op_sign[1], EXP_ONES, {FRAC_W{1'b0}}};
            status[ST_INF] = 1'b1;
        end else begin
            z                  = z_fin;
            status[ST_ZERO]    = f_zero | zero_pair;
            status[ST_INF]     = f_inf;
            status[ST_TINY]    = f_tiny;
            status[ST_HUGE]    = f_huge;
            status[ST_INEXACT] = f_inexact;
        end
        status[ST_HUGEINT] = 1'b0;
        status[ST_DIVZ]    = 1'b0;
    end

endmodule

// File: rtl/fpadd_chk.sv
// Assertion checker for fpadd_core, attached by bind. It checks relations
// between the port values; the block has no clock, so the checks are
// immediate assertions evaluated whenever the ports settle.
module fpadd_chk #(
    parameter int EXP_W     = 8,
    parameter int FRAC_W    = 23,
    parameter int IEEE_MODE = 1,
    localparam int WORD_W   = 1 + EXP_W + FRAC_W
) (
    input logic [WORD_W-1:0] a,
    input logic [WORD_W-1:0] b,
    input logic [2:0]        rnd,
    input logic [WORD_W-1:0] z,
    input logic [7:0]        status
);

    logic z_exp1, z_frac0, a_exp1, b_exp1, a_inf, b_inf;

    assign z_exp1  = &z[WORD_W-2:FRAC_W];
    assign z_frac0 = (z[FRAC_W-1:0] == '0);
    assign a_exp1  = &a[WORD_W-2:FRAC_W];
    assign b_exp1  = &b[WORD_W-2:FRAC_W];
    assign a_inf   = a_exp1 && (a[FRAC_W-1:0] == '0);
    assign b_inf   = b_exp1 && (b[FRAC_W-1:0] == '0);

    // Port-level consistency checks once inputs are known.
    always_comb begin
        if (!$isunknown({a, b, rnd})) begin
            a_r11_spare_bits_low: assert (status[7:6] == 2'b00)
                else $error("R11 spare status bits set");
            a_r4_nan_pattern: assert (!z_exp1 || z_frac0 ||
                                      ((IEEE_MODE != 0) && (z[FRAC_W-1:0] == FRAC_W'(1))))
                else $error("R4 produced NaN has wrong fraction");
            a_r5_clash_invalid: assert (!(a_inf && b_inf && (a[WORD_W-1] != b[WORD_W-1])) || status[2])
                else $error("R5 opposite infinities without invalid");
            a_r6_inf_flag: assert (status[1] == (z_exp1 && z_frac0))
                else $error("R6 infinity flag disagrees with z");
            a_r8_zero_flag: assert (status[0] == (z[WORD_W-2:0] == '0))
                else $error("R8 zero flag disagrees with z");
            a_r7_huge_inexact: assert (!status[4] || status[5])
                else $error("R7 huge without inexact");
            a_r3_tiny_exp: assert (!status[3] || (z[WORD_W-2:FRAC_W] == '0))
                else $error("R3 tiny with nonzero exponent");
            a_r2_rtz_finite: assert (!((rnd == 3'd1) && !a_exp1 && !b_exp1) || !z_exp1)
                else $error("R2 toward-zero produced infinity");
        end
    end

endmodule

bind fpadd_core fpadd_chk #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .IEEE_MODE(IEEE_MODE)
) u_chk (
    .a(a), .b(b), .rnd(rnd), .z(z), .status(status)
);

// File: tb/sim_fpadd_core.sv
module sim_fpadd_core;

    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 2000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] a0, b0, z0, a2, b2, z2;
    logic [15:0] a1, b1, z1;
    logic [2:0]  r0, r1, r2;
    logic [7:0]  s0, s1, s2;

    fpadd_core #(.EXP_W(8), .FRAC_W(23), .IEEE_MODE(1)) u0 (
        .a(a0), .b(b0), .rnd(r0), .z(z0), .status(s0));
    fpadd_core #(.EXP_W(5), .FRAC_W(10), .IEEE_MODE(1)) u1 (
        .a(a1), .b(b1), .rnd(r1), .z(z1), .status(s1));
    fpadd_core #(.EXP_W(8), .FRAC_W(23), .IEEE_MODE(0)) u2 (
        .a(a2), .b(b2), .rnd(r2), .z(z2), .status(s2));

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Exact reference: returns {status, z} from integer arithmetic.
    function automatic logic [39:0] ref_add(input int ew, input int fw, input bit ieee,
                                            input logic [31:0] a, input logic [31:0] b,
                                            input logic [2:0] rm);
        int emax, ea, eb, p, k, ex;
        logic sa, sb, s, nan_a, nan_b, inf_a, inf_b, inex, up, to_inf;
        logic [31:0] fa, fb, fmask, nanw, res;
        logic [319:0] na, nb, ns, mant, rem, half;
        emax  = (1 << ew) - 1;
        fmask = (32'd1 << fw) - 32'd1;
        sa = a[ew+fw]; sb = b[ew+fw];
        ea = int'((a >> fw) & 32'(emax)); eb = int'((b >> fw) & 32'(emax));
        fa = a & fmask; fb = b & fmask;
        nan_a = ieee && ea == emax && fa != 0; nan_b = ieee && eb == emax && fb != 0;
        inf_a = ea == emax && !nan_a; inf_b = eb == emax && !nan_b;
        nanw  = (32'(emax) << fw) | 32'd1;
        if (nan_a || nan_b) return {8'h04, nanw};
        if (inf_a && inf_b && sa != sb)
            return ieee ? {8'h04, nanw} : {8'h06, 32'(emax) << fw};
        if (inf_a) return {8'h02, (32'(sa) << (ew+fw)) | (32'(emax) << fw)};
        if (inf_b) return {8'h02, (32'(sb) << (ew+fw)) | (32'(emax) << fw)};
        na = (ea == 0) ? (ieee ? 320'(fa) : 320'd0) : 320'((32'd1 << fw) | fa);
        nb = (eb == 0) ? (ieee ? 320'(fb) : 320'd0) : 320'((32'd1 << fw) | fb);
        na = na << ((ea == 0 ? 1 : ea) - 1);
        nb = nb << ((eb == 0 ? 1 : eb) - 1);
        if (sa == sb) begin ns = na + nb; s = sa; end
        else if (na > nb) begin ns = na - nb; s = sa; end
        else begin ns = nb - na; s = sb; end
        if (ns == 0) begin
            s = (sa == sb) ? sa : (rm == 3'd3);
            return {8'h01, 32'(s) << (ew+fw)};
        end
        p = 0;
        for (int i = 0; i < 320; i++) if (ns[i]) p = i;
        k    = (p > fw) ? p - fw : 0;
        ex   = (p >= fw) ? k + 1 : 0;
        mant = ns >> k;
        rem  = ns & ((320'd1 << k) - 320'd1);
        half = (k > 0) ? (320'd1 << (k-1)) : 320'd0;
        inex = (rem != 0);
        case (rm)
            3'd1: up = 0;
            3'd2: up = inex && !s;
            3'd3: up = inex && s;
            3'd4: up = inex && rem >= half;
            3'd5: up = inex;
            default: up = inex && (rem > half || (rem == half && mant[0]));
        endcase
        mant = mant + 320'(up);
        if (mant == (320'd1 << (fw+1))) begin mant = mant >> 1; ex = ex + 1; end
        if (ex == 0 && mant[fw]) ex = 1;
        if (ex >= emax) begin
            to_inf = (rm == 3'd1) ? 1'b0 : (rm == 3'd2) ? !s : (rm == 3'd3) ? s : 1'b1;
            res = to_inf ? ((32'(s) << (ew+fw)) | (32'(emax) << fw))
                         : ((32'(s) << (ew+fw)) | (32'(emax-1) << fw) | fmask);
            return {to_inf ? 8'h32 : 8'h30, res};
        end
        if (ex == 0 && !ieee) return {8'h29, 32'(s) << (ew+fw)};
        res = (32'(s) << (ew+fw)) | (32'(ex) << fw) | (32'(mant) & fmask);
        return {(inex ? 8'h20 : 8'h00) | (ex == 0 ? 8'h08 : 8'h00), res};
    endfunction

    // Random operand biased toward special, boundary and cancelling values.
    function automatic logic [31:0] gen(input int ew, input int fw);
        int emax, e;
        logic [31:0] fr, sg;
        emax = (1 << ew) - 1;
        sg = 32'($urandom & 1);
        fr = $urandom & ((32'd1 << fw) - 32'd1);
        case ($urandom % 16)
            0: begin e = 0; fr = 0; end
            1: begin e = emax; fr = 0; end
            2: begin e = emax; fr = fr | 32'd1; end
            3: e = 0;
            4, 5: e = emax - 1 - int'($urandom % 3);
            6, 7: e = 1 + int'($urandom % 3);
            default: e = 1 + int'($urandom % 32'(emax - 1));
        endcase
        return (sg << (ew+fw)) | (32'(e) << fw) | fr;
    endfunction

    // Apply one vector to an instance and compare with the reference.
    task automatic check(input int which, input logic [31:0] a, input logic [31:0] b,
                         input logic [2:0] rm, input string tag);
        logic [39:0] exp_v;
        logic [31:0] gz;
        logic [7:0]  gs;
        @(posedge clk);
        case (which)
            0: begin a0 = a; b0 = b; r0 = rm; end
            1: begin a1 = a[15:0]; b1 = b[15:0]; r1 = rm; end
            default: begin a2 = a; b2 = b; r2 = rm; end
        endcase
        @(negedge clk);
        case (which)
            0: begin gz = z0; gs = s0; exp_v = ref_add(8, 23, 1, a, b, rm); end
            1: begin gz = {16'h0, z1}; gs = s1; exp_v = ref_add(5, 10, 1, a, b, rm); end
            default: begin gz = z2; gs = s2; exp_v = ref_add(8, 23, 0, a, b, rm); end
        endcase
        n_tests++;
        if (gz !== exp_v[31:0] || gs !== exp_v[39:32]) begin
            n_fail++;
            $display("FAIL %s dut%0d a=%h b=%h rnd=%0d got z=%h st=%b exp z=%h st=%b",
                     tag, which, a, b, rm, gz, gs, exp_v[31:0], exp_v[39:32]);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] x, y;
        void'($urandom(32'd2024));
        a0 = 0; b0 = 0; r0 = 0; a1 = 0; b1 = 0; r1 = 0; a2 = 0; b2 = 0; r2 = 0;
        // R1 plain sums
        check(0, 32'h3F800000, 32'h3F800000, 3'd0, "R1 one plus one");
        check(0, 32'h3FC00000, 32'hBF000000, 3'd0, "R1 mixed sign");
        // R2, R9 tie and near-tie under every code
        for (int m = 0; m < 8; m++) begin
            check(0, 32'h3F800000, 32'h33800000, 3'(m), "R2 R9 tie");
            check(0, 32'hBF800001, 32'hB3800000, 3'(m), "R2 R9 negative tie");
            check(0, 32'h3F800000, 32'h33000001, 3'(m), "R2 below half");
        end
        // R3 subnormal results
        check(0, 32'h00000001, 32'h00000001, 3'd0, "R3 subnormal sum");
        check(0, 32'h00800000, 32'h80000001, 3'd0, "R3 normal to subnormal");
        // R4 NaN input
        check(0, 32'h7FC00000, 32'h3F800000, 3'd0, "R4 nan input");
        check(0, 32'h00000000, 32'hFF800005, 3'd2, "R4 nan second");
        // R5 opposite infinities
        check(0, 32'h7F800000, 32'hFF800000, 3'd0, "R5 inf clash");
        check(2, 32'h7F800000, 32'hFF800000, 3'd0, "R5 inf clash flush mode");
        // R6 single infinity
        check(0, 32'hFF800000, 32'h3F800000, 3'd0, "R6 neg inf");
        check(0, 32'h7F800000, 32'h7F800000, 3'd1, "R6 same infs");
        // R7 overflow in each mode
        for (int m = 0; m < 6; m++) begin
            check(0, 32'h7F7FFFFF, 32'h7F7FFFFF, 3'(m), "R7 overflow pos");
            check(0, 32'hFF7FFFFF, 32'hFF7FFFFF, 3'(m), "R7 overflow neg");
        end
        // R8 zero signs
        check(0, 32'h3F800000, 32'hBF800000, 3'd0, "R8 cancel");
        check(0, 32'h3F800000, 32'hBF800000, 3'd3, "R8 cancel down");
        check(0, 32'h80000000, 32'h80000000, 3'd0, "R8 neg zeros");
        check(0, 32'h00000000, 32'h80000000, 3'd3, "R8 mixed zeros down");
        // R10 flush mode
        check(2, 32'h00000001, 32'h00000001, 3'd0, "R10 subnormal inputs");
        check(2, 32'h00800001, 32'h80800000, 3'd0, "R10 flushed result");
        check(2, 32'h7FC00000, 32'h3F800000, 3'd0, "R10 nan as inf");
        check(2, 32'h80000003, 32'h00000000, 3'd3, "R10 flushed operands zero");
        // R12 half precision
        check(1, 32'h3C00, 32'h3C00, 3'd0, "R12 half one plus one");
        check(1, 32'h0001, 32'h83FF, 3'd0, "R12 half subnormal");
        check(1, 32'h7BFF, 32'h7BFF, 3'd1, "R12 half overflow");
        // R1 R2 R9 R11 random mix on all three instances
        for (int w = 0; w < 3; w++) begin
            for (int i = 0; i < N_RAND; i++) begin
                int ew, fw;
                ew = (w == 1) ? 5 : 8;
                fw = (w == 1) ? 10 : 23;
                x = gen(ew, fw);
                case ($urandom % 4)
                    0: y = x ^ (32'd1 << (ew+fw)) ^ ($urandom & 32'h7);
                    1: y = (x & ~((32'd1 << fw) - 32'd1)) | ($urandom & ((32'd1 << fw) - 32'd1));
                    default: y = gen(ew, fw);
                endcase
                check(w, x, y, 3'($urandom % 8), "R1 R2 R9 R11 random");
            end
        end
        summary();
    end

endmodule